// File: doc/BRIEF.md
# Shared Mailbox Hub with Aggregated Interrupt Lines

The hub holds up to eight 32-bit mailbox words, each owned by one producer/consumer pair. The top bit of each word is the occupancy flag: a producer posts a message by writing a word with that bit set, and a consumer releases the mailbox by writing a word with it clear. Writing zero releases the mailbox and wipes the payload. Each mailbox has a two-state machine. `SLOT_IDLE` means empty and `SLOT_HELD` means full. The `POST` transition (a data write with bit 31 set) moves `SLOT_IDLE` to `SLOT_HELD`. The `DRAIN` transition (a data write with bit 31 clear) moves `SLOT_HELD` to `SLOT_IDLE`. Any other data write rewrites the payload and leaves the state unchanged.

Every mailbox drives two level-sensitive status bits, empty and full. These are packed into one status word. A bank of enable words, one per shared interrupt line, masks that status. Each line is the OR of its masked bits, so an enabled condition holds its line high for as long as the condition lasts. An optional variant adds a per-mailbox full-enable and empty-enable. A status bit then reaches the lines only when both its per-mailbox enable and the line's enable are set. A read-only word reports the configured resource counts.

Access uses a plain read/write strobe bus with byte addresses.

The register map is:
- Line enables: `0x100 + 4*x`.
- Line levels: `0x300`.
- Raw status: `0x304`.
- Dimensions: `0x380`.
- Mailbox `k`: `0x400 + 16*k`, with data at +0x0, full-enable at +0x4 and empty-enable at +0x8.

Top module: `shmbox_hub`

## Requirements
- R1: After reset every mailbox reads 0, every enable register reads 0, and every interrupt line is low.
- R2: A write to a mailbox data word with bit 31 set stores all 32 bits. The mailbox then reads back that word and reports full (status bit 8+k set, bit k clear).
- R3: A write to a mailbox data word with bit 31 clear stores the word, so a write of zero clears the payload. The mailbox then reports empty (bit k set, bit 8+k clear). A mailbox word changes only on a write to it.
- R4: The status word at 0x304 holds empty flags in bits [7:0] and full flags in bits [15:8], indexed by mailbox. Bits [31:16] are 0, and both bits of a mailbox index at or above the configured count are 0.
- R5: The enable register for line x is at 0x100+4x and holds 16 bits that read back. Line x is high exactly when the gated status AND enable x is nonzero. The line follows the registers one cycle after a write and stays high while the condition holds.
- R6: With per-mailbox enables present, bit 0 at mailbox offset +0x4 gates the full bit and bit 0 at +0x8 gates the empty bit. Both reset to 0, and a status bit whose per-mailbox enable is 0 never raises any line.
- R7: A read of 0x300 returns the current interrupt line levels in bits [N_SHINT-1:0], with 0 above.
- R8: A read of 0x380 returns 4-bit counts: mailboxes at [3:0], shared semaphores at [7:4], arbitrated semaphores at [11:8], doorbells at [15:12], shared lines at [19:16], and 0 above.
- R9: Reads of a mailbox index at or above the configured count, of a line enable at or above the line count, or of any unmapped address return 0. Writes to those addresses change no state.
- R10: `rdata` is loaded on the clock edge that samples `rd_en` high, with the value from before any same-cycle write. It holds while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | N_SHINT | Shared interrupt lines |

## Verification
A corrupted mailbox state machine or payload shows up on the next read of that mailbox or of the status word. It also appears on every enabled interrupt line one cycle after the write that caused it. A wrong enable or gate register shows up as a line level that disagrees with the model at the first check after the write, and that check runs every cycle of stimulus. Decode faults that alias an unimplemented slot onto a real one show up as a changed status word after the stray write.

// File: rtl/shmbox_pkg.sv
package shmbox_pkg;
    localparam int ADDR_W   = 12;
    localparam int MAX_MBOX = 8;
    localparam int STAT_W   = 2 * MAX_MBOX;

    localparam logic [ADDR_W-1:0] OFS_LINE_EN   = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_LINE_LVL  = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_STATUS    = 12'h304;
    localparam logic [ADDR_W-1:0] OFS_DIM       = 12'h380;
    localparam logic [4:0]        MB_WIN_TAG    = 5'b01000;   // 0x400..0x47F

    localparam logic [3:0] SUB_DATA = 4'h0;
    localparam logic [3:0] SUB_FIE  = 4'h4;
    localparam logic [3:0] SUB_EIE  = 4'h8;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;
endpackage

// File: rtl/shmbox_slot.sv
module shmbox_slot
    import shmbox_pkg::*;
#(
    parameter bit PER_IE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_data_en,
    input  logic        wr_fie_en,
    input  logic        wr_eie_en,
    input  logic [31:0] wdata,
    output logic [31:0] word_o,
    output logic        full_o,
    output logic        empty_o,
    output logic        fie_o,
    output logic        eie_o
);
    slot_state_e state_q, state_d;
    logic [30:0] payload_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (wr_data_en && wdata[31])  state_d = SLOT_HELD;  // POST
            SLOT_HELD: if (wr_data_en && !wdata[31]) state_d = SLOT_IDLE;  // DRAIN
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SLOT_IDLE;
            payload_q <= '0;
        end else begin
            state_q <= state_d;
            if (wr_data_en) payload_q <= wdata[30:0];
        end
    end

    always_comb begin
        full_o  = (state_q == SLOT_HELD);
        empty_o = (state_q == SLOT_IDLE);
        word_o  = {full_o, payload_q};
    end

    generate
        if (PER_IE) begin : g_gate
            logic fie_q, eie_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fie_q <= 1'b0;
                    eie_q <= 1'b0;
                end else begin
                    if (wr_fie_en) fie_q <= wdata[0];
                    if (wr_eie_en) eie_q <= wdata[0];
                end
            end
            assign fie_o = fie_q;
            assign eie_o = eie_q;
        end else begin : g_nogate
            assign fie_o = 1'b1;
            assign eie_o = 1'b1;
        end
    endgenerate

    assert_post_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_en && wdata[31]) |=> (full_o && word_o[30:0] == $past(wdata[30:0])));
    assert_drain_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_en && !wdata[31]) |=> (empty_o && word_o == $past(wdata)));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data_en |=> $stable(word_o));
endmodule

// File: rtl/shmbox_irq_bank.sv
module shmbox_irq_bank
    import shmbox_pkg::*;
#(
    parameter int N_LINES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [N_LINES-1:0]              wr_sel,
    input  logic [STAT_W-1:0]               wdata,
    input  logic [STAT_W-1:0]               gated_stat,
    output logic [N_LINES-1:0][STAT_W-1:0]  en_o,
    output logic [N_LINES-1:0]              irq_o
);
    generate
        for (genvar x = 0; x < N_LINES; x++) begin : g_line
            logic [STAT_W-1:0] en_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                en_q <= '0;
                else if (wr_en && wr_sel[x]) en_q <= wdata;
            end
            assign en_o[x]  = en_q;
            assign irq_o[x] = |(gated_stat & en_q);

            assert_mask_zero_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel[x] && wdata == '0) |=> !irq_o[x]);
        end
    endgenerate
endmodule

// File: rtl/shmbox_hub.sv
module shmbox_hub
    import shmbox_pkg::*;
#(
    parameter int N_MBOX    = 4,
    parameter int N_SHINT   = 2,
    parameter int N_SSEM    = 2,
    parameter int N_ASEM    = 2,
    parameter int N_DBELL   = 4,
    parameter bit PER_MB_IE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [11:0]        addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [N_SHINT-1:0] irq_o
);
    localparam logic [31:0] DIM_WORD = {12'd0, 4'(N_SHINT), 4'(N_DBELL),
                                        4'(N_ASEM), 4'(N_SSEM), 4'(N_MBOX)};

    logic [31:0]         words [MAX_MBOX];
    logic [MAX_MBOX-1:0] full_v, empty_v, fie_v, eie_v;
    logic [STAT_W-1:0]   status, gated;
    logic [N_SHINT-1:0][STAT_W-1:0] en_w;
    logic [N_SHINT-1:0]  line_sel;

    logic       is_mb, is_line;
    logic [2:0] mb_idx;
    logic [3:0] mb_sub;
    logic [5:0] line_idx;

    assign is_mb    = (addr[11:7] == MB_WIN_TAG);
    assign mb_idx   = addr[6:4];
    assign mb_sub   = addr[3:0];
    assign is_line  = (addr[11:8] == OFS_LINE_EN[11:8]) && (addr[1:0] == 2'b00);
    assign line_idx = addr[7:2];

    generate
        for (genvar k = 0; k < MAX_MBOX; k++) begin : g_mb
            if (k < N_MBOX) begin : g_on
                logic sel;
                assign sel = wr_en && is_mb && (mb_idx == 3'(k));
                shmbox_slot #(.PER_IE(PER_MB_IE)) u_slot (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .wr_data_en (sel && mb_sub == SUB_DATA),
                    .wr_fie_en  (sel && mb_sub == SUB_FIE),
                    .wr_eie_en  (sel && mb_sub == SUB_EIE),
                    .wdata      (wdata),
                    .word_o     (words[k]),
                    .full_o     (full_v[k]),
                    .empty_o    (empty_v[k]),
                    .fie_o      (fie_v[k]),
                    .eie_o      (eie_v[k])
                );
            end else begin : g_off
                assign words[k]   = '0;
                assign full_v[k]  = 1'b0;
                assign empty_v[k] = 1'b0;
                assign fie_v[k]   = 1'b0;
                assign eie_v[k]   = 1'b0;
            end
        end
        for (genvar x = 0; x < N_SHINT; x++) begin : g_sel
            assign line_sel[x] = is_line && (line_idx == 6'(x));
        end
    endgenerate

    assign status = {full_v, empty_v};
    assign gated  = {full_v & fie_v, empty_v & eie_v};

    shmbox_irq_bank #(.N_LINES(N_SHINT)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (line_sel),
        .wdata      (wdata[STAT_W-1:0]),
        .gated_stat (gated),
        .en_o       (en_w),
        .irq_o      (irq_o)
    );

    logic [31:0] rd_d;
    always_comb begin
        rd_d = '0;
        if (is_mb) begin
            if (int'(mb_idx) < N_MBOX) begin
                case (mb_sub)
                    SUB_DATA: rd_d = words[mb_idx];
                    SUB_FIE:  rd_d = PER_MB_IE ? {31'd0, fie_v[mb_idx]} : 32'd0;
                    SUB_EIE:  rd_d = PER_MB_IE ? {31'd0, eie_v[mb_idx]} : 32'd0;
                    default:  rd_d = '0;
                endcase
            end
        end else if (is_line) begin
            for (int x = 0; x < N_SHINT; x++)
                if (line_idx == 6'(x)) rd_d = {16'd0, en_w[x]};
        end else if (addr == OFS_LINE_LVL) begin
            rd_d = 32'(irq_o);
        end else if (addr == OFS_STATUS) begin
            rd_d = {16'd0, status};
        end else if (addr == OFS_DIM) begin
            rd_d = DIM_WORD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_d;
    end

    assert_status_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:0] & status[15:8]) == 8'd0);
    assert_unimpl_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_mb && int'(mb_idx) >= N_MBOX) |=> (rdata == 32'd0));
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/shmbox_hub_tb.sv
module shmbox_hub_tb;
    localparam int NMB = 4;
    localparam int NSH = 2;

    logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NSH-1:0] irq_o;

    int vectors = 0, fails = 0;

    logic [31:0] mb_m  [8];
    logic        fie_m [8];
    logic        eie_m [8];
    logic [15:0] en_m  [NSH];

    always #5 clk = ~clk;

    shmbox_hub #(.N_MBOX(NMB), .N_SHINT(NSH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

    function automatic logic [15:0] m_status();
        logic [15:0] s = '0;
        for (int k = 0; k < NMB; k++) begin
            s[k]     = ~mb_m[k][31];
            s[8 + k] =  mb_m[k][31];
        end
        return s;
    endfunction

    function automatic logic [NSH-1:0] m_irq();
        logic [15:0] s = m_status();
        logic [15:0] g = '0;
        logic [NSH-1:0] r;
        for (int k = 0; k < NMB; k++) begin
            g[k]     = s[k] & eie_m[k];
            g[8 + k] = s[8 + k] & fie_m[k];
        end
        for (int x = 0; x < NSH; x++) r[x] = |(g & en_m[x]);
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int k = int'(a[6:4]);
        int x = int'(a[7:2]);
        if (a[11:7] == 5'b01000) begin
            if (k >= NMB) return 32'd0;
            case (a[3:0])
                4'h0: return mb_m[k];
                4'h4: return {31'd0, fie_m[k]};
                4'h8: return {31'd0, eie_m[k]};
                default: return 32'd0;
            endcase
        end
        if (a[11:8] == 4'h1 && a[1:0] == 2'b00) return (x < NSH) ? {16'd0, en_m[x]} : 32'd0;
        if (a == 12'h300) return 32'(m_irq());
        if (a == 12'h304) return {16'd0, m_status()};
        if (a == 12'h380) return {12'd0, 4'(NSH), 4'd4, 4'd2, 4'd2, 4'(NMB)};
        return 32'd0;
    endfunction

    task automatic m_write(input logic [11:0] a, input logic [31:0] d);
        int k = int'(a[6:4]);
        int x = int'(a[7:2]);
        if (a[11:7] == 5'b01000 && k < NMB) begin
            if (a[3:0] == 4'h0) mb_m[k]  = d;
            if (a[3:0] == 4'h4) fie_m[k] = d[0];
            if (a[3:0] == 4'h8) eie_m[k] = d[0];
        end else if (a[11:8] == 4'h1 && a[1:0] == 2'b00 && x < NSH) begin
            en_m[x] = d[15:0];
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_write(a, d);
        chk("R5 irq after write", 32'(irq_o), 32'(m_irq()));
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        logic [31:0] e = m_read(a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rdata, e);
    endtask

    function automatic logic [11:0] pick_addr();
        int r = int'($urandom_range(0, 9));
        case (r)
            0, 1, 2: return 12'h400 + 12'(16 * $urandom_range(0, 7));
            3:       return 12'h404 + 12'(16 * $urandom_range(0, 4));
            4:       return 12'h408 + 12'(16 * $urandom_range(0, 4));
            5:       return 12'h100 + 12'(4 * $urandom_range(0, 3));
            6:       return 12'h304;
            7:       return 12'h300;
            8:       return 12'h380;
            default: return 12'h40C;
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 8; k++) begin mb_m[k] = '0; fie_m[k] = 0; eie_m[k] = 0; end
        for (int x = 0; x < NSH; x++) en_m[x] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq at reset", 32'(irq_o), 32'd0);
        for (int k = 0; k < NMB; k++) rd(12'h400 + 12'(16 * k), "R1 mailbox reset");
        for (int x = 0; x < NSH; x++) rd(12'h100 + 12'(4 * x), "R1 enable reset");
        rd(12'h304, "R4 status after reset");
        rd(12'h380, "R8 dimension word");

        // R2 post / R3 drain
        wr(12'h400, 32'h8000_1234);
        rd(12'h400, "R2 posted word");
        rd(12'h304, "R2 full status");
        wr(12'h400, 32'h0000_0055);
        rd(12'h400, "R3 drained word");
        wr(12'h400, 32'h0);
        rd(12'h400, "R3 zero clears");
        rd(12'h304, "R3 empty status");

        // R6 gating: line enable without per-mailbox enable stays low
        wr(12'h410, 32'hFFFF_FFFF);
        wr(12'h100, 32'h0000_0200);
        chk("R6 gated off", 32'(irq_o), 32'd0);
        wr(12'h414, 32'h1);
        chk("R6 gated on", 32'(irq_o), 32'd1);
        rd(12'h300, "R7 line levels");

        // R5 level: empty enabled on idle mailbox holds line
        wr(12'h428, 32'h1);
        wr(12'h104, 32'h0000_0004);
        repeat (4) begin
            @(negedge clk);
            chk("R5 level holds", 32'(irq_o), 32'(m_irq()));
        end
        chk("R5 line1 high", 32'(irq_o[1]), 32'd1);

        // R9 unimplemented slot and line
        wr(12'h450, 32'h8000_00AA);
        rd(12'h450, "R9 unimpl mailbox");
        rd(12'h304, "R9 status unchanged");
        wr(12'h10C, 32'hFFFF);
        rd(12'h10C, "R9 unimpl enable");
        rd(12'h200, "R9 unmapped");

        // R10 rdata holds when not reading
        rd(12'h380, "R10 read load");
        keep = rdata;
        wr(12'h420, 32'h8765_4321);
        chk("R10 rdata hold", rdata, keep);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a = pick_addr();
            if ($urandom_range(0, 1) == 0) begin
                logic [31:0] d = $urandom();
                if ($urandom_range(0, 3) == 0) d = 32'd0;
                wr(a, d);
            end else begin
                rd(a, "R4 random read");
            end
        end
        rd(12'h304, "R4 final status");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule